// File: doc/BRIEF.md
# Framing Byte Error Counter

This block sits on the receive side of a byte-wide STS-1 stream, one byte per clock. A frame-start strobe marks the first byte of each frame. The block follows the byte position through the 9-row by 90-column frame. It compares the two framing bytes at the head of row 1 against their fixed patterns and adds every mismatch to a 16-bit error count. Checking pauses while the loss-of-frame input is high, and no byte is checked before the first frame-start strobe.

Software reads the count through a byte-wide register port at two adjacent addresses.

- Reading the high byte clears the live count and freezes the low byte in a holding register.
- A later read of the low byte returns the frozen value, so both halves always describe the same interval.

A single enable bit lets the line defect inputs force an alarm indication signal onto every tributary output at once, for as long as any defect is present.

Top module: `fbyte_err_counter`

## Requirements
- R1: After reset, the count high byte, the held low byte and the control register all read 0x00, and no tributary AIS output is high.
- R2: The byte that carries the frame-start strobe is compared with 0xF6, and the byte that follows it is compared with 0x28. Each mismatch adds one to the count. No other byte of the frame is ever counted.
- R3: The byte position runs through 810 positions and restarts at every frame-start strobe. Bytes that arrive before the first strobe after reset are not checked.
- R4: While the loss-of-frame input is high, framing mismatches are not counted.
- R5: A read at address 0x026E returns count bits 15:8, copies count bits 7:0 into the holding register, and clears the live count.
- R6: A read at address 0x026F returns the held low byte and then resets it to 0x00.
- R7: A framing mismatch in the same cycle as a read at 0x026E becomes the first error of the new count (the count reads 1 afterwards).
- R8: The count saturates at 0xFFFF and does not wrap.
- R9: The control register at address 0x0260 holds the AIS enable in bit 0, is written through the register port and reads back with bits 7:1 as zero.
- R10: When the enable is 1 and any of the LOS, LOF, SD, SF or AIS-L inputs is high, all 28 tributary AIS outputs are high in that cycle. Otherwise all of them are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Incoming stream byte |
| rx_fs | input | 1 | High on the first byte of a frame |
| dfct_los | input | 1 | Loss of signal declared |
| dfct_lof | input | 1 | Loss of frame declared; also pauses checking |
| dfct_sd | input | 1 | Signal degrade declared |
| dfct_sf | input | 1 | Signal fail declared |
| dfct_ais_l | input | 1 | Line AIS declared |
| reg_addr | input | 16 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe; read data is valid in the same cycle |
| reg_rdata | output | 8 | Register read data |
| trib_ais | output | 28 | AIS request, one line per tributary |

## Verification
The embedded properties check, on every cycle, these rules of the counter:

- it moves by at most one per cycle;
- it holds its value while loss of frame is high;
- it stays at 0xFFFF once it saturates;
- a high-byte read leaves it at 0 or 1 and freezes the correct low byte.

Other behaviour can only be shown by the bench's scenarios:

- which byte positions are compared, against which patterns;
- that nothing is checked before the first frame-start strobe;
- how the two register halves pair up across a clearing read;
- the AIS fan-out for each defect input.

// File: rtl/fbyte_err_counter.sv
module fbyte_err_counter #(
  parameter int ROWS = 9,
  parameter int COLS = 90,
  parameter int N_TRIB = 28,
  parameter int ADDR_W = 16,
  parameter logic [7:0] A1_PAT = 8'hF6,
  parameter logic [7:0] A2_PAT = 8'h28,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0260,
  parameter logic [ADDR_W-1:0] CNT_HI_ADDR = 16'h026E,
  parameter logic [ADDR_W-1:0] CNT_LO_ADDR = 16'h026F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        rx_byte,
  input  logic              rx_fs,
  input  logic              dfct_los,
  input  logic              dfct_lof,
  input  logic              dfct_sd,
  input  logic              dfct_sf,
  input  logic              dfct_ais_l,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_rd,
  output logic [7:0]        reg_rdata,
  output logic [N_TRIB-1:0] trib_ais
);
  localparam int FRM_LEN = ROWS * COLS;
  localparam int POS_W = $clog2(FRM_LEN);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRM_LEN - 1);

  logic [POS_W-1:0] pos_q;
  logic             synced_q;
  logic [15:0]      cnt_q;
  logic [7:0]       hold_lo_q;
  logic             ais_en_q;

  logic [POS_W-1:0] cur_pos;
  logic             checking, a1_bad, a2_bad, err_now, rd_hi, rd_lo, any_dfct;

  assign cur_pos  = rx_fs ? '0 : pos_q;
  assign checking = (rx_fs | synced_q) & ~dfct_lof;
  assign a1_bad   = (cur_pos == POS_W'(0)) && (rx_byte != A1_PAT);
  assign a2_bad   = (cur_pos == POS_W'(1)) && (rx_byte != A2_PAT);
  assign err_now  = checking & (a1_bad | a2_bad);
  assign rd_hi    = reg_rd && (reg_addr == CNT_HI_ADDR);
  assign rd_lo    = reg_rd && (reg_addr == CNT_LO_ADDR);
  assign any_dfct = dfct_los | dfct_lof | dfct_sd | dfct_sf | dfct_ais_l;
  assign trib_ais = {N_TRIB{ais_en_q & any_dfct}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q    <= '0;
      synced_q <= 1'b0;
    end else begin
      if (rx_fs) synced_q <= 1'b1;
      pos_q <= (cur_pos == LAST_POS) ? '0 : cur_pos + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      hold_lo_q <= '0;
    end else if (rd_hi) begin
      cnt_q     <= {15'd0, err_now};
      hold_lo_q <= cnt_q[7:0];
    end else begin
      if (err_now && cnt_q != 16'hFFFF) cnt_q <= cnt_q + 16'd1;
      if (rd_lo) hold_lo_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ais_en_q <= 1'b0;
    else if (reg_wr && reg_addr == CTRL_ADDR) ais_en_q <= reg_wdata[0];
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == CNT_HI_ADDR) reg_rdata = cnt_q[15:8];
    else if (reg_addr == CNT_LO_ADDR) reg_rdata = hold_lo_q;
    else if (reg_addr == CTRL_ADDR) reg_rdata = {7'd0, ais_en_q};
  end

  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hi |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 16'd1));

  // R4
  lof_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dfct_lof && !rd_hi) |=> $stable(cnt_q));

  // R5
  hi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> cnt_q <= 16'd1);

  // R5
  snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> hold_lo_q == $past(cnt_q[7:0]));

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == 16'hFFFF && !rd_hi) |=> cnt_q == 16'hFFFF);
endmodule

// File: tb/fbyte_err_counter_tb.sv
module fbyte_err_counter_tb;
  localparam int FRM = 810;
  localparam logic [15:0] A_CTRL = 16'h0260, A_HI = 16'h026E, A_LO = 16'h026F;

  logic clk = 0, rst_n = 0;
  logic [7:0] rx_byte = 0, reg_wdata = 0, reg_rdata;
  logic rx_fs = 0, los = 0, lof = 0, sd = 0, sf = 0, aisl = 0, reg_wr = 0, reg_rd = 0;
  logic [15:0] reg_addr = 0;
  logic [27:0] trib_ais;

  int total = 0, bad = 0;
  bit stream_on = 0, all_err = 0;
  int p = 0, bad_a1 = 0, bad_a2 = 0;

  logic [7:0] exp_q[$];
  bit chk_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  fbyte_err_counter u_dut (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_fs(rx_fs),
    .dfct_los(los), .dfct_lof(lof), .dfct_sd(sd), .dfct_sf(sf), .dfct_ais_l(aisl),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .trib_ais(trib_ais));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (!stream_on) begin
        rx_fs = 0; rx_byte = 8'h00;
      end else if (all_err) begin
        rx_fs = 1; rx_byte = 8'h00; p = 1;
      end else begin
        rx_fs = (p == 0);
        if (p == 0) begin
          rx_byte = (bad_a1 > 0) ? 8'h0F : 8'hF6;
          if (bad_a1 > 0) bad_a1--;
        end else if (p == 1) begin
          rx_byte = (bad_a2 > 0) ? 8'hD7 : 8'h28;
          if (bad_a2 > 0) bad_a2--;
        end else rx_byte = 8'h00;
        p = (p == FRM - 1) ? 0 : p + 1;
      end
    end
  end

  always @(negedge clk) begin : monitor
    logic [7:0] e;
    bit c;
    string t;
    if (reg_rd) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 1, 0);
      else begin
        e = exp_q.pop_front(); c = chk_q.pop_front(); t = tag_q.pop_front();
        if (c) check(t, reg_rdata, e);
      end
    end
  end

  task automatic rd(logic [15:0] a, logic [7:0] e, bit c, string t);
    @(posedge clk); #1;
    reg_addr = a; reg_rd = 1;
    exp_q.push_back(e); chk_q.push_back(c); tag_q.push_back(t);
    @(posedge clk); #1;
    reg_rd = 0;
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic wait_frames(int n);
    repeat (n * FRM + 4) @(negedge clk);
  endtask

  task automatic set_dfct(logic [4:0] v);
    @(negedge clk);
    {los, lof, sd, sf, aisl} = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 no AIS after reset", trib_ais, 0);
    rd(A_HI, 8'h00, 1, "R1 count high after reset");
    rd(A_LO, 8'h00, 1, "R1 held low after reset");
    rd(A_CTRL, 8'h00, 1, "R1 control after reset");

    repeat (900) @(negedge clk);
    rd(A_HI, 8'h00, 1, "R3 no check before first strobe");
    rd(A_LO, 8'h00, 1, "R3 no check before first strobe low");

    @(negedge clk); stream_on = 1;
    wait_frames(3);
    rd(A_HI, 8'h00, 1, "R2 clean frames high");
    rd(A_LO, 8'h00, 1, "R2 clean frames, other bytes ignored");

    @(negedge clk); bad_a1 = 1;
    wait_frames(2);
    rd(A_HI, 8'h00, 1, "R2 A1 error high");
    rd(A_LO, 8'h01, 1, "R2 single A1 error");

    @(negedge clk); bad_a2 = 1;
    wait_frames(2);
    rd(A_HI, 8'h00, 1, "R2 A2 error high");
    rd(A_LO, 8'h01, 1, "R2 single A2 error");

    @(negedge clk); bad_a1 = 2; bad_a2 = 2;
    wait_frames(3);
    rd(A_HI, 8'h00, 1, "R2 mixed errors high");
    rd(A_LO, 8'h04, 1, "R2 four errors over two frames");

    @(negedge clk); lof = 1; bad_a1 = 1; bad_a2 = 1;
    wait_frames(2);
    @(negedge clk); lof = 0;
    rd(A_HI, 8'h00, 1, "R4 suspended high");
    rd(A_LO, 8'h00, 1, "R4 errors under loss of frame not counted");

    @(negedge clk); bad_a1 = 3; bad_a2 = 2;
    wait_frames(4);
    rd(A_HI, 8'h00, 1, "R5 snapshot read high");
    @(negedge clk); bad_a1 = 2;
    wait_frames(3);
    rd(A_LO, 8'h05, 1, "R6 held low survives new errors");
    rd(A_LO, 8'h00, 1, "R6 held low clears on read");
    rd(A_HI, 8'h00, 1, "R5 fresh count high");
    rd(A_LO, 8'h02, 1, "R5 fresh count low");

    @(negedge clk); all_err = 1;
    repeat (300) @(negedge clk);
    all_err = 0;
    repeat (4) @(negedge clk);
    rd(A_HI, 8'h01, 1, "R5 count 300 high byte");
    rd(A_LO, 8'h2C, 1, "R5 count 300 low byte");

    @(negedge clk); all_err = 1;
    repeat (10) @(negedge clk);
    @(posedge clk); #1;
    reg_addr = A_HI; reg_rd = 1;
    exp_q.push_back(8'h00); chk_q.push_back(1); tag_q.push_back("R7 high byte at coincident read");
    @(negedge clk); all_err = 0;
    @(posedge clk); #1; reg_rd = 0;
    repeat (3) @(negedge clk);
    rd(A_LO, 8'h0A, 1, "R7 held count before coincident read");
    rd(A_HI, 8'h00, 1, "R7 new count high");
    rd(A_LO, 8'h01, 1, "R7 coincident error kept");

    @(negedge clk); all_err = 1;
    repeat (65540) @(negedge clk);
    all_err = 0;
    repeat (4) @(negedge clk);
    rd(A_HI, 8'hFF, 1, "R8 saturated high");
    rd(A_LO, 8'hFF, 1, "R8 saturated low");
    rd(A_HI, 8'h00, 1, "R8 cleared after saturation high");
    rd(A_LO, 8'h00, 1, "R8 cleared after saturation low");

    set_dfct(5'b00010);
    check("R10 defect with enable off", trib_ais, 0);
    set_dfct(5'b00000);
    wr(A_CTRL, 8'hFF);
    rd(A_CTRL, 8'h01, 1, "R9 enable readback");
    set_dfct(5'b00000);
    check("R10 enable without defect", trib_ais, 0);
    for (int i = 0; i < 5; i++) begin
      set_dfct(5'b1 << i);
      check($sformatf("R10 AIS on defect %0d", i), trib_ais, 28'hFFFFFFF);
    end
    set_dfct(5'b11111);
    check("R10 all defects", trib_ais, 28'hFFFFFFF);
    set_dfct(5'b00000);
    check("R10 AIS released", trib_ais, 0);
    wr(A_CTRL, 8'h00);
    rd(A_CTRL, 8'h00, 1, "R9 enable cleared");
    set_dfct(5'b01000);
    check("R10 disabled again", trib_ais, 0);
    set_dfct(5'b00000);

    repeat (3) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule